// File: doc/BRIEF.md
# SPI Flash Command Engine

A memory-mapped SPI master that runs one serial-flash command for each start request. Software writes a one-byte command code into its own register and sets the outgoing and incoming byte counts in a packed count register. It loads the outgoing payload through a byte-wide data port into an eight-entry FIFO, then sets the start bit. The engine drives chip select low and shifts out the command code first. It then sends the payload bytes and clocks in the requested number of reply bytes, after which it releases chip select.

The outgoing payload and the incoming reply share one FIFO and one pointer. Replies land in the slots that follow the payload, so the payload stays where software put it. Software rewinds the pointer, steps past its own payload through the auto-incrementing data port, and reads the reply. The serial side runs in SPI mode 0, with the serial clock half-period set by a parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high and the serial clock is low. The control register (offset 0x2), the status register (offset 0x3) and the pointer register (offset 0xD) all read 0x00.
- R2: Offset 0x0 holds the command code. Offset 0x1 holds the reply count in bits 7:4 and the payload count in bits 3:0. Both registers read back the value last written.
- R3: A write to the data port (offset 0xC) stores the byte at the current pointer. A read of the data port returns the byte at the pointer. Either access then moves the pointer up by one, modulo 8. The pointer reads back in bits 2:0 of offset 0xD.
- R4: Writing control with bit 4 set returns the pointer to 0.
- R5: Writing control with bit 0 set starts a command. From the next cycle until the frame ends, control bit 0 and status bit 7 read 1 and chip select is low. Both bits drop to 0 when chip select is released.
- R6: A frame keeps chip select low from the first bit to the last. It carries exactly 8*(1+tx+rx) rising clock edges, with each byte sent MSB first. The command code goes first. The payload follows, taken from FIFO slots 0 to tx-1. The reply phase follows, with MOSI sending 0x00. The clock idles low and MISO is sampled on the rising edge (mode 0).
- R7: The reply byte with index i is stored in FIFO slot (tx+i) mod 8. The payload slots keep their contents.
- R8: With a payload count of 0, the engine clocks exactly the programmed reply count and stores every reply byte from slot 0 onward.
- R9: While a frame runs, writes to the command, count and data registers are ignored, a data write does not move the pointer, and a further start request has no effect.
- R10: When tx+rx exceeds 8, the later reply bytes wrap and overwrite the earliest FIFO slots.
- R11: The serial clock stays high for SCK_HALF system clock cycles on each pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong pointer shows up at once: the pointer readback at offset 0xD and the next data-port read both disagree on the very next access. A wrong frame index or slot mapping does not show until the frame ends. It appears as extra or missing clock edges in the captured frame and as reply bytes sitting in the wrong FIFO slots, which a full rewind-and-read of all eight slots reveals. A busy lockout that leaks shows up after the frame as a changed command or count readback, a moved pointer, or a second chip-select pulse.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam int IDX_W  = CNT_W + 1;

  localparam logic [3:0] ADR_OPCODE = 4'h0;
  localparam logic [3:0] ADR_COUNTS = 4'h1;
  localparam logic [3:0] ADR_CTRL   = 4'h2;
  localparam logic [3:0] ADR_STATUS = 4'h3;
  localparam logic [3:0] ADR_DATA   = 4'hC;
  localparam logic [3:0] ADR_PTR    = 4'hD;

  localparam int CTRL_GO_BIT  = 0;
  localparam int CTRL_RWD_BIT = 4;
  localparam int STAT_BSY_BIT = 7;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LOAD, ENG_WAIT} eng_state_e;

  // Index of the last byte in a frame; byte 0 is the command code.
  function automatic logic [IDX_W-1:0] last_index(input logic [CNT_W-1:0] tx,
                                                  input logic [CNT_W-1:0] rx);
    return IDX_W'(tx) + IDX_W'(rx);
  endfunction

  // Frame byte k (k >= 1) comes from the payload when k <= tx.
  function automatic logic is_payload(input logic [IDX_W-1:0] k,
                                      input logic [CNT_W-1:0] tx);
    return (k != '0) && (k <= IDX_W'(tx));
  endfunction

  // Frame byte k is a reply byte when k > tx.
  function automatic logic is_reply(input logic [IDX_W-1:0] k,
                                    input logic [CNT_W-1:0] tx);
    return k > IDX_W'(tx);
  endfunction
endpackage

// File: rtl/scmd_fifo.sv
`timescale 1ns/1ps
module scmd_fifo #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_clr,
  input  logic             sw_wr,
  input  logic             sw_adv,
  input  logic [7:0]       sw_wdata,
  output logic [7:0]       sw_rdata,
  output logic [PTR_W-1:0] ptr,
  input  logic [PTR_W-1:0] eng_idx,
  output logic [7:0]       eng_rdata,
  input  logic             eng_wr,
  input  logic [7:0]       eng_wdata
);
  logic [7:0] mem [DEPTH];

  assign sw_rdata  = mem[ptr];
  assign eng_rdata = mem[eng_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (ptr_clr) ptr <= '0;
    else if (sw_wr || sw_adv) ptr <= ptr + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else if (eng_wr && eng_idx == PTR_W'(g)) mem[g] <= eng_wdata;
      else if (sw_wr && ptr == PTR_W'(g)) mem[g] <= sw_wdata;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !eng_wr) |=> mem[$past(ptr)] == $past(sw_wdata)); // R3
endmodule

// File: rtl/scmd_shifter.sv
`timescale 1ns/1ps
module scmd_shifter #(
  parameter int SCK_HALF = 2,
  localparam int DIV_W = $clog2(SCK_HALF + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       done,
  output logic       active
);
  logic [7:0]       sh;
  logic [DIV_W-1:0] div;
  logic [2:0]       bit_n;
  logic             half_tick;

  assign half_tick = (div == DIV_W'(SCK_HALF - 1));
  assign mosi      = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; div <= '0; bit_n <= '0; sck <= 1'b0;
      rx_byte <= '0; done <= 1'b0; active <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        sh     <= tx_byte;
        sck    <= 1'b0;
        div    <= '0;
        bit_n  <= '0;
      end else if (active) begin
        if (half_tick) begin
          div <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_n == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_n <= bit_n + 1'b1;
              sh    <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end

  AST_GO_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active); // R6
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int SCK_HALF   = 2,
  parameter int FIFO_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);

  logic [7:0]       opcode_q, counts_q;
  logic             busy;
  logic [IDX_W-1:0] k;
  eng_state_e       state;
  logic [CNT_W-1:0] tx_n, rx_n;

  // named events
  logic             start_req, ptr_clr, sw_wr, sw_adv, eng_wr, go, byte_done;
  logic             sh_active;
  logic [PTR_W-1:0] ptr, slot;
  logic [7:0]       sw_rdata, eng_rdata, tx_sel, rx_byte;

  assign tx_n      = counts_q[CNT_W-1:0];
  assign rx_n      = counts_q[BYTE_W-1:CNT_W];
  assign start_req = reg_wr && reg_addr == ADR_CTRL && reg_wdata[CTRL_GO_BIT] && !busy;
  assign ptr_clr   = reg_wr && reg_addr == ADR_CTRL && reg_wdata[CTRL_RWD_BIT];
  assign sw_wr     = reg_wr && reg_addr == ADR_DATA && !busy;
  assign sw_adv    = reg_rd && reg_addr == ADR_DATA;
  assign slot      = PTR_W'(k - 1'b1);
  assign go        = (state == ENG_LOAD);
  assign eng_wr    = (state == ENG_WAIT) && byte_done && is_reply(k, tx_n);

  always_comb begin
    if (k == '0) tx_sel = opcode_q;
    else if (is_payload(k, tx_n)) tx_sel = eng_rdata;
    else tx_sel = 8'h00;
  end

  always_comb begin
    unique case (reg_addr)
      ADR_OPCODE: reg_rdata = opcode_q;
      ADR_COUNTS: reg_rdata = counts_q;
      ADR_CTRL:   reg_rdata = 8'(busy) << CTRL_GO_BIT;
      ADR_STATUS: reg_rdata = 8'(busy) << STAT_BSY_BIT;
      ADR_DATA:   reg_rdata = sw_rdata;
      ADR_PTR:    reg_rdata = 8'(ptr);
      default:    reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0;
      counts_q <= '0;
    end else if (reg_wr && !busy) begin
      if (reg_addr == ADR_OPCODE) opcode_q <= reg_wdata;
      if (reg_addr == ADR_COUNTS) counts_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ENG_IDLE; busy <= 1'b0; spi_cs_n <= 1'b1; k <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: if (start_req) begin
          state <= ENG_LOAD; busy <= 1'b1; spi_cs_n <= 1'b0; k <= '0;
        end
        ENG_LOAD: state <= ENG_WAIT;
        ENG_WAIT: if (byte_done) begin
          if (k == last_index(tx_n, rx_n)) begin
            state <= ENG_IDLE; busy <= 1'b0; spi_cs_n <= 1'b1;
          end else begin
            k <= k + 1'b1; state <= ENG_LOAD;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  scmd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .sw_wr(sw_wr), .sw_adv(sw_adv),
    .sw_wdata(reg_wdata), .sw_rdata(sw_rdata), .ptr(ptr), .eng_idx(slot),
    .eng_rdata(eng_rdata), .eng_wr(eng_wr), .eng_wdata(rx_byte)
  );

  scmd_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .tx_byte(tx_sel), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .rx_byte(rx_byte), .done(byte_done),
    .active(sh_active)
  );

  AST_SCK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R6
  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n); // R5
  AST_OPCODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == ADR_OPCODE) |=> $stable(opcode_q)); // R9
  AST_PTR_REWOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_CTRL && reg_wdata[CTRL_RWD_BIT]) |=> ptr == '0); // R4
  AST_REPLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr |-> (busy && !spi_cs_n && !sh_active)); // R7
endmodule

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
  localparam int SCK_HALF = 2;
  localparam logic [3:0] A_OPC = 4'h0, A_CNT = 4'h1, A_CTL = 4'h2,
                         A_STS = 4'h3, A_DAT = 4'hC, A_PTR = 4'hD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int vectors = 0, miscompares = 0;
  int rise_cnt = 0, frames = 0;
  time last_rise = 0, hi_time = 0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;
  logic [7:0] mosi_cap [0:31];
  logic [7:0] pl  [0:7];
  logic [7:0] expf [0:7];

  always #4 clk = ~clk;

  spi_cmd_engine #(.SCK_HALF(SCK_HALF), .FIFO_DEPTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] resp(input int j);
    return 8'h5A + 8'(j * 19);
  endfunction

  function automatic logic resp_bit(input int n);
    logic [7:0] r;
    r = resp(n / 8);
    return r[7 - (n % 8)];
  endfunction

  // flash model, mode 0
  always @(spi_sck or spi_cs_n) begin
    if (prev_cs === 1'b1 && spi_cs_n === 1'b0) begin
      rise_cnt = 0;
      spi_miso = resp_bit(0);
    end else if (spi_cs_n === 1'b0 && prev_sck === 1'b0 && spi_sck === 1'b1) begin
      if (rise_cnt < 256) mosi_cap[rise_cnt / 8][7 - (rise_cnt % 8)] = spi_mosi;
      rise_cnt++;
      last_rise = $time;
    end else if (spi_cs_n === 1'b0 && prev_sck === 1'b1 && spi_sck === 1'b0) begin
      spi_miso = resp_bit(rise_cnt);
      hi_time = $time - last_rise;
    end
    if (prev_cs === 1'b0 && spi_cs_n === 1'b1) frames++;
    prev_sck = spi_sck;
    prev_cs  = spi_cs_n;
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] s;
    int n = 0;
    do begin rd(A_STS, s); n++; end while (s[7] && n < 5000);
    if (n >= 5000) chk(tag, s, 8'h00);
  endtask

  task automatic launch(input logic [7:0] op, input int tx, input int rx);
    wr(A_CTL, 8'h10);
    wr(A_OPC, op);
    wr(A_CNT, {4'(rx), 4'(tx)});
    for (int i = 0; i < tx; i++) begin wr(A_DAT, pl[i]); expf[i] = pl[i]; end
    wr(A_CTL, 8'h10);
    wr(A_CTL, 8'h01);
    for (int i = 0; i < rx; i++) expf[(tx + i) % 8] = resp(1 + tx + i);
  endtask

  task automatic check_frame(input string tag, input logic [7:0] op, input int tx, input int rx);
    logic [7:0] d;
    chk_int({tag, " rising edges"}, rise_cnt, 8 * (1 + tx + rx));
    chk({tag, " command byte"}, mosi_cap[0], op);
    for (int i = 0; i < tx; i++) chk({tag, " payload byte"}, mosi_cap[1 + i], pl[i]);
    for (int i = 0; i < rx; i++) chk({tag, " reply-phase mosi"}, mosi_cap[1 + tx + i], 8'h00);
    wr(A_CTL, 8'h10);
    for (int i = 0; i < 8; i++) begin
      rd(A_DAT, d);
      chk({tag, " fifo slot"}, d, expf[i]);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 cs_n", 8'(spi_cs_n), 8'h01);
    chk("R1 sck", 8'(spi_sck), 8'h00);
    rd(A_CTL, d); chk("R1 ctrl", d, 8'h00);
    rd(A_STS, d); chk("R1 status", d, 8'h00);
    rd(A_PTR, d); chk("R1 ptr", d, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(A_OPC, 8'h3B); wr(A_CNT, 8'h52);
    rd(A_OPC, d); chk("R2 opcode", d, 8'h3B);
    rd(A_CNT, d); chk("R2 counts", d, 8'h52);
  endtask

  task automatic t_pointer();
    logic [7:0] d;
    wr(A_CTL, 8'h10);
    for (int i = 0; i < 3; i++) begin wr(A_DAT, 8'hA1 + 8'(i)); expf[i] = 8'hA1 + 8'(i); end
    rd(A_PTR, d); chk("R3 ptr after writes", d, 8'h03);
    wr(A_CTL, 8'h10);
    rd(A_PTR, d); chk("R4 ptr rewound", d, 8'h00);
    for (int i = 0; i < 3; i++) begin rd(A_DAT, d); chk("R3 data readback", d, expf[i]); end
    rd(A_PTR, d); chk("R3 ptr after reads", d, 8'h03);
    for (int i = 3; i < 8; i++) begin wr(A_DAT, 8'hB0 + 8'(i)); expf[i] = 8'hB0 + 8'(i); end
    rd(A_PTR, d); chk("R3 ptr wraps", d, 8'h00);
    rd(A_DAT, d); chk("R3 slot0 after wrap", d, expf[0]);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    int f0;
    pl[0] = 8'hC7; pl[1] = 8'h19;
    f0 = frames;
    launch(8'h0B, 2, 3);
    rd(A_CTL, d); chk("R5 ctrl go while running", d, 8'h01);
    rd(A_STS, d); chk("R5 status busy", d, 8'h80);
    chk("R5 cs low while running", 8'(spi_cs_n), 8'h00);
    wait_idle("R5 completion");
    rd(A_CTL, d); chk("R5 ctrl self-clears", d, 8'h00);
    chk("R5 cs released", 8'(spi_cs_n), 8'h01);
    chk_int("R6 single cs pulse", frames - f0, 1);
    chk_int("R11 sck high time", int'(hi_time), SCK_HALF * 8);
    check_frame("R6 R7 basic", 8'h0B, 2, 3);
  endtask

  task automatic t_rx_only();
    check_frame_prep();
  endtask

  task automatic check_frame_prep();
    launch(8'h9F, 0, 4);
    wait_idle("R8 completion");
    check_frame("R8 no payload", 8'h9F, 0, 4);
  endtask

  task automatic t_busy_lock();
    logic [7:0] d;
    int f0;
    pl[0] = 8'h42;
    f0 = frames;
    launch(8'h05, 1, 1);
    wr(A_OPC, 8'h11);
    wr(A_CNT, 8'h77);
    wr(A_DAT, 8'hEE);
    wr(A_CTL, 8'h01);
    rd(A_PTR, d); chk("R9 ptr unmoved by busy write", d, 8'h00);
    wait_idle("R9 completion");
    repeat (100) @(negedge clk);
    chk_int("R9 no second frame", frames - f0, 1);
    chk("R9 cs idle", 8'(spi_cs_n), 8'h01);
    rd(A_OPC, d); chk("R9 opcode kept", d, 8'h05);
    rd(A_CNT, d); chk("R9 counts kept", d, 8'h11);
    check_frame("R9 locked frame", 8'h05, 1, 1);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 6; i++) pl[i] = 8'h10 + 8'(i * 3);
    launch(8'h02, 6, 4);
    wait_idle("R10 completion");
    check_frame("R10 wrap", 8'h02, 6, 4);
  endtask

  initial begin
    #1_200_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin expf[i] = 8'h00; pl[i] = 8'h00; end
    for (int i = 0; i < 32; i++) mosi_cap[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_pointer();
    t_basic();
    t_rx_only();
    t_busy_lock();
    t_wrap();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule